// File: doc/BRIEF.md
# I2C Operating Mode Control Register

This block holds the two mode bits of an I2C controller. The master-select bit and the transmit-select bit together choose one of four operating modes. The mode is driven to the rest of the controller and can be read back by the CPU. Software sets the bits through a simple byte-wide register port. The bus engine can also change them through three inputs: arbitration lost, the read/write bit of the first frame received as a slave, and a format-switch level.

When hardware changes a bit, that bit is locked against software writes. The lock is released by a CPU read, which returns the value that hardware left behind. This stops a write based on stale state from undoing a hardware decision. When a hardware event and a software write reach the same bit in the same cycle, the hardware event wins.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: `mode_o` is {master, transmit}: 2'b00 is slave receive, 2'b01 is slave transmit, 2'b10 is master receive and 2'b11 is master transmit. `mst_o` and `trs_o` carry the same two bits.
- R2: After reset both bits are 0 (slave receive) and neither bit is locked.
- R3: A clock edge that samples `arb_lost_i`=1 while master is 1 clears both bits from the next cycle on. When master is 0, `arb_lost_i` has no effect.
- R4: A clock edge that samples `sw_i`=0, when the previous edge sampled `sw_i`=1, clears the transmit bit from the next cycle on. The master bit is not touched.
- R5: A clock edge that samples `slv_vld_i`=1 and `slv_rw_i`=1 while master is 0 sets the transmit bit. If `slv_rw_i`=0 or master is 1, nothing changes.
- R6: Each event in R3 to R5 locks every bit it acts on. While a bit is locked, writes to it are ignored. A clock edge that samples `cpu_rd_i`=1 unlocks every bit, and writes on later edges take effect.
- R7: On a clock edge with `cpu_wr_i`=1, each unlocked bit takes its data bit: `cpu_wdata_i[5]` for master and `cpu_wdata_i[4]` for transmit. The new value is visible in the next cycle.
- R8: In the same cycle, a hardware event beats a software write to the same bit. For the transmit bit, a clear beats a set.
- R9: `cpu_rdata_o` shows master in bit 5 and transmit in bit 4, and all other bits read 0. It follows the bits combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_rd_i | input | 1 | Register read strobe |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data |
| arb_lost_i | input | 1 | Arbitration lost after a master transmission started |
| slv_vld_i | input | 1 | First-frame R/W bit valid in slave mode |
| slv_rw_i | input | 1 | First-frame R/W bit value |
| sw_i | input | 1 | Format-switch level |
| mst_o | output | 1 | Master select |
| trs_o | output | 1 | Transmit select |
| mode_o | output | 2 | Operating mode {master, transmit} |

## Verification
Every strobe and event changes the mode bits exactly one clock after the edge that samples it. A format-switch fall needs two edges: one that sees 1 and a later one that sees 0. A read unlocks the bits at its own edge, so a write on the next edge already takes effect. Read data is combinational and is due in the same cycle as the bits it shows. The bench drives inputs on the falling clock edge and advances a behavioural model on the rising edge. It compares the mode and the read data on the following falling edge, so each result is checked in the cycle it is first due.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int MST_POS = 5;
  localparam int TRS_POS = 4;
  localparam int NBITS   = 2;
  localparam int IDX_MST = 1;
  localparam int IDX_TRS = 0;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;
endpackage

// File: rtl/mode_edge_det.sv
module mode_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/mode_bit_cell.sv
module mode_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic q_o
);
  logic q_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= 1'b0;
      lock_q <= 1'b0;
    end else if (hw_clr_i || hw_set_i) begin
      q_q    <= ~hw_clr_i;  // clear beats set
      lock_q <= 1'b1;
    end else begin
      if (wr_i && !lock_q) q_q <= wd_i;
      if (rd_i) lock_q <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              arb_lost_i,
  input  logic              slv_vld_i,
  input  logic              slv_rw_i,
  input  logic              sw_i,
  output logic              mst_o,
  output logic              trs_o,
  output logic [1:0]        mode_o
);
  logic              sw_fall, arb_hit, slv_set;
  logic [NBITS-1:0]  hw_set, hw_clr, bit_q;

  mode_edge_det u_sw_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sw_i),
    .fall_o (sw_fall)
  );

  assign arb_hit = arb_lost_i & bit_q[IDX_MST];
  assign slv_set = slv_vld_i & slv_rw_i & ~bit_q[IDX_MST];

  assign hw_clr[IDX_MST] = arb_hit;
  assign hw_set[IDX_MST] = 1'b0;
  assign hw_clr[IDX_TRS] = arb_hit | sw_fall;
  assign hw_set[IDX_TRS] = slv_set;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    localparam int POS = (g == IDX_MST) ? MST_POS : TRS_POS;
    mode_bit_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hw_set_i (hw_set[g]),
      .hw_clr_i (hw_clr[g]),
      .rd_i     (cpu_rd_i),
      .wr_i     (cpu_wr_i),
      .wd_i     (cpu_wdata_i[POS]),
      .q_o      (bit_q[g])
    );
  end

  always_comb begin
    cpu_rdata_o          = '0;
    cpu_rdata_o[MST_POS] = bit_q[IDX_MST];
    cpu_rdata_o[TRS_POS] = bit_q[IDX_TRS];
  end

  assign mst_o  = bit_q[IDX_MST];
  assign trs_o  = bit_q[IDX_TRS];
  assign mode_o = mode_e'({bit_q[IDX_MST], bit_q[IDX_TRS]});
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk
  import i2c_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_wr_i,
  input logic              cpu_rd_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              arb_lost_i,
  input logic              slv_vld_i,
  input logic              slv_rw_i,
  input logic              sw_i,
  input logic              mst_o,
  input logic              trs_o,
  input logic [1:0]        mode_o
);
  logic sw_prev, lk_m, lk_t;
  logic arb_ev, fall_ev, slv_ev;

  assign arb_ev  = arb_lost_i && mst_o;
  assign fall_ev = sw_prev && !sw_i;
  assign slv_ev  = slv_vld_i && slv_rw_i && !mst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_prev <= 1'b0;
      lk_m    <= 1'b0;
      lk_t    <= 1'b0;
    end else begin
      sw_prev <= sw_i;
      if (arb_ev) lk_m <= 1'b1;
      else if (cpu_rd_i) lk_m <= 1'b0;
      if (arb_ev || fall_ev || slv_ev) lk_t <= 1'b1;
      else if (cpu_rd_i) lk_t <= 1'b0;
    end
  end

  AST_MODE_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == {mst_o, trs_o}); // R1

  AST_ARB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_ev |=> (!mst_o && !trs_o)); // R3

  AST_SW_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_ev |=> !trs_o); // R4

  AST_SLV_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_ev && !fall_ev) |=> trs_o); // R5

  AST_MST_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && lk_m && !arb_ev) |=> $stable(mst_o)); // R6

  AST_TRS_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && lk_t && !arb_ev && !fall_ev && !slv_ev) |=> $stable(trs_o)); // R6

  AST_FREE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !lk_m && !arb_ev) |=> mst_o == $past(cpu_wdata_i[MST_POS])); // R7

  AST_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && fall_ev) |=> !trs_o); // R8

  always_comb begin
    if (rst_ni) begin
      AST_RDATA_MAP: assert (cpu_rdata_o[MST_POS] == mst_o && cpu_rdata_o[TRS_POS] == trs_o
        && $countones(cpu_rdata_o) == int'(mst_o) + int'(trs_o)); // R9
    end
  end
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rdata_o (cpu_rdata_o),
  .arb_lost_i  (arb_lost_i),
  .slv_vld_i   (slv_vld_i),
  .slv_rw_i    (slv_rw_i),
  .sw_i        (sw_i),
  .mst_o       (mst_o),
  .trs_o       (trs_o),
  .mode_o      (mode_o)
);

// File: tb/tb_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_mode_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 0, rd = 0, arb = 0, sv = 0, rw = 0, sw = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          mst, trs;
  logic [1:0]    mode;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_mst = 0, m_trs = 0, m_lock_m = 0, m_lock_t = 0, m_sw_last = 0;

  always #2.5 clk = ~clk;

  i2c_mode_ctrl #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_rd_i(rd),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .arb_lost_i(arb),
    .slv_vld_i(sv), .slv_rw_i(rw), .sw_i(sw),
    .mst_o(mst), .trs_o(trs), .mode_o(mode)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic compare(input string tag);
    int exp_rd;
    exp_rd = (m_mst << 5) | (m_trs << 4);
    n_chk++;
    if (mode !== 2'(m_mst * 2 + m_trs) || mst !== 1'(m_mst) || trs !== 1'(m_trs)) begin
      n_bad++;
      $display("FAIL %s mode actual=%b expected=%0d%0d", tag, mode, m_mst, m_trs);
    end
    n_chk++;
    if (rdata !== DW'(exp_rd)) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h (R9)", tag, rdata, DW'(exp_rd));
    end
  endtask

  task automatic model_edge();
    bit hm, ht, clr_t, set_t, fall;
    fall  = (m_sw_last == 1) && (sw == 1'b0);
    hm    = arb && (m_mst == 1);
    clr_t = hm || fall;
    set_t = sv && rw && (m_mst == 0);
    ht    = clr_t || set_t;
    if (hm) begin m_mst = 0; m_lock_m = 1; end
    else begin
      if (wr && m_lock_m == 0) m_mst = wdata[5];
      if (rd) m_lock_m = 0;
    end
    if (ht) begin m_trs = clr_t ? 0 : 1; m_lock_t = 1; end
    else begin
      if (wr && m_lock_t == 0) m_trs = wdata[4];
      if (rd) m_lock_t = 0;
    end
    m_sw_last = sw;
  endtask

  // one cycle: drive after negedge, model on posedge, compare on next negedge
  task automatic cyc(input bit w, input bit r, input logic [7:0] d,
                     input bit a, input bit v, input bit b, input string tag);
    wr = w; rd = r; wdata = d; arb = a; sv = v; rw = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr = 0; rd = 0; arb = 0; sv = 0; rw = 0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R2 after release");

    // R7 plain writes, R1 all four encodings
    cyc(1, 0, 8'h30, 0, 0, 0, "R7 R1 master tx");
    cyc(1, 0, 8'h20, 0, 0, 0, "R7 R1 master rx");
    cyc(1, 0, 8'h10, 0, 0, 0, "R7 R1 slave tx");
    cyc(1, 0, 8'hCF, 0, 0, 0, "R7 R1 slave rx other bits");
    cyc(0, 0, 8'h00, 0, 0, 0, "R1 idle");

    // R3 arbitration loss and R6 interlock
    cyc(1, 0, 8'h30, 0, 0, 0, "R7 set 11");
    cyc(0, 0, 8'h00, 1, 0, 0, "R3 arb clears both");
    cyc(1, 0, 8'h30, 0, 0, 0, "R6 write while locked");
    cyc(0, 1, 8'h00, 0, 0, 0, "R6 read unlocks");
    cyc(1, 0, 8'h30, 0, 0, 0, "R6 write after read");

    // R3 ignored in slave mode
    cyc(1, 0, 8'h10, 0, 0, 0, "R7 slave tx");
    cyc(0, 0, 8'h00, 1, 0, 0, "R3 arb ignored in slave");
    cyc(1, 0, 8'h00, 0, 0, 0, "R7 back to slave rx");

    // R5 slave first-frame R/W
    cyc(0, 0, 8'h00, 0, 1, 0, "R5 rw=0 no change");
    cyc(0, 0, 8'h00, 0, 1, 1, "R5 rw=1 sets trs");
    cyc(1, 0, 8'h20, 0, 0, 0, "R6 trs locked mst free");
    cyc(0, 1, 8'h00, 0, 0, 0, "R6 read");
    cyc(1, 0, 8'h20, 0, 0, 0, "R6 trs write after read");
    cyc(0, 0, 8'h00, 0, 1, 1, "R5 ignored in master");

    // R4 format-switch falling edge
    cyc(1, 0, 8'h30, 0, 0, 0, "R7 set 11");
    sw = 1'b1;
    cyc(0, 0, 8'h00, 0, 0, 0, "R4 switch high no change");
    sw = 1'b0;
    cyc(0, 0, 8'h00, 0, 0, 0, "R4 fall clears trs");
    cyc(0, 0, 8'h00, 0, 0, 0, "R4 low stays");
    cyc(1, 0, 8'h30, 0, 0, 0, "R6 trs locked after fall");
    cyc(0, 1, 8'h00, 0, 0, 0, "R6 read");

    // R8 hardware beats software
    cyc(1, 0, 8'h30, 1, 0, 0, "R8 arb beats write");
    cyc(0, 1, 8'h00, 0, 0, 0, "R6 read");
    cyc(1, 0, 8'h10, 0, 0, 0, "R7 slave tx");
    sw = 1'b1;
    cyc(0, 0, 8'h00, 0, 0, 0, "R4 switch high");
    sw = 1'b0;
    cyc(1, 0, 8'h10, 0, 1, 1, "R8 fall beats set and write");
    cyc(0, 1, 8'h00, 0, 1, 1, "R8 read same cycle as set");
    cyc(1, 0, 8'h00, 0, 0, 0, "R6 still locked");

    // R2 async reset mid-run
    cyc(0, 1, 8'h00, 0, 0, 0, "R6 read");
    cyc(1, 0, 8'h30, 0, 0, 0, "R7 set 11");
    rst_n = 1'b0;
    m_mst = 0; m_trs = 0; m_lock_m = 0; m_lock_t = 0; m_sw_last = 0;
    #1;
    compare("R2 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 8'h20, 0, 0, 0, "R2 R7 unlocked after reset");

    finish_run();
  end
endmodule